// File: doc/BRIEF.md
# ISA Bus Sizing Sequencer

This block connects a 16-bit host request port to an ISA-style expansion bus. A host request is a byte or a word, read or write, at any byte address. The block runs one or two bus cycles for each request. It drives the address, the active-low byte-high-enable line and the two byte lanes of the data bus. During the address phase it samples the card's active-low 16-bit acknowledge, and it uses that sample to pick the lane routing for the request.

A word request becomes two byte cycles when the card is 8-bit wide, and also when the card is 16-bit wide and the address is odd. The odd-address case uses crossed lanes: the low byte travels on the upper lane and the high byte on the lower lane. The host sees a single stall signal that stays high from acceptance until the response. For a read, the bytes captured in the one or two data phases are merged into one 16-bit result.

Each request moves through the same phases. An address phase of one clock comes first. Then comes a data phase of `DATA_CYC` clocks with the command strobe low. A split request adds a one-clock address step, followed by a second data phase. A final one-clock response phase ends the request.

Top module: `isa_size_seq`

## Requirements
- R1: While reset is held, and in the first clock after it is released, `req_stall` and `rsp_valid` are 0, both command strobes are 1, both lane enables are 0 and `bus_sbhe_n` is 1.
- R2: Every bus cycle obeys one byte-enable rule, and the pair (`bus_sbhe_n`, A0) = (1, 1) never appears while a strobe is low.
  - In a first cycle, `bus_sbhe_n` is 0 for a word request or an odd address.
  - In a first cycle, `bus_sbhe_n` is 1 for a byte request at an even address.
  - In a second cycle, `bus_sbhe_n` is the inverse of that cycle's A0.
- R3: `bus_cs16_n` is sampled only on the last clock of the address phase (0 means a 16-bit card). That sample governs the whole request, and changes on the line during the data phases have no effect.
- R4: A byte transfer to an 8-bit card uses the lower lane (bits 7:0) at both even and odd addresses.
- R5: A byte transfer to a 16-bit card uses the lower lane at an even address and the upper lane (bits 15:8) at an odd address.
- R6: A word transfer to an 8-bit card runs two cycles on the lower lane: the low byte at address A, then the high byte at A+1.
- R7: A word transfer to a 16-bit card at an even address runs one cycle on both lanes, with bits 15:0 carried unchanged.
- R8: A word transfer to a 16-bit card at an odd address runs two cycles: the low byte on the upper lane at A, then the high byte on the lower lane at A+1.
- R9: `req_stall` goes high on the clock after acceptance and stays high through the response clock.
  - With `DATA_CYC`=4 the request lasts 6 clocks for one cycle and 11 clocks for a split.
  - A request is accepted only when `req_valid` is 1 and `req_stall` is 0.
  - Inputs presented while stalled are ignored.
- R10: In each data phase, exactly one strobe is low, for exactly `DATA_CYC` clocks: `bus_rd_n` for a read and `bus_wr_n` for a write.
- R11: `rsp_valid` is a one-clock pulse at the end of a request, and `rsp_rdata` holds the read result at that time.
  - A byte read returns the byte in bits 7:0, with bits 15:8 zero.
  - A word read returns the byte at A in bits 7:0 and the byte at A+1 in bits 15:8.
  - Lanes are captured on the last clock of each data phase.
- R12: The lane output enables rise only while `bus_wr_n` is low, and only for the lane or lanes carrying data. A read never enables a lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data (a byte request uses bits 7:0) |
| req_stall | output | 1 | Host held; no new request taken |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result |
| bus_addr | output | AW | Bus address |
| bus_sbhe_n | output | 1 | Active-low byte-high enable |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_cs16_n | input | 1 | Active-low 16-bit card acknowledge |
| bus_dout | output | 16 | Write data toward the bus |
| bus_oe_lo | output | 1 | Drive enable, lower lane |
| bus_oe_hi | output | 1 | Drive enable, upper lane |
| bus_din | input | 16 | Read data from the bus |

## Verification
The assertions check the cycle-level rules on every clock:
- the (1, 1) pair of byte-enable and A0 never appears on an active cycle;
- the held 16-bit sample stays stable after the address phase;
- the strobes are mutually exclusive and the data-phase counter stays in range;
- the address steps by one into the second cycle, which drives only the lower lane;
- stall and response are ordered correctly.

Only the bench scenarios can show the rest:
- that each card width and address parity gets the right lane and byte order;
- that written bytes land in the right place and read bytes come back merged in the right order;
- that a 16-bit acknowledge toggling during a data phase changes nothing.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DATA1 = 3'd2,
    ST_INCR  = 3'd3,
    ST_DATA2 = 3'd4,
    ST_DONE  = 3'd5
  } seq_st_e;

  typedef enum logic [1:0] {
    LANE_LO   = 2'd0,
    LANE_HI   = 2'd1,
    LANE_BOTH = 2'd2
  } lane_e;

  // A word needs two byte cycles unless the card is wide and the address even.
  function automatic logic f_split(input logic word, input logic card16, input logic a0);
    return word && (!card16 || a0);
  endfunction

  // Byte-high enable (active low): the upper byte is involved for a word or an odd address.
  function automatic logic f_sbhe_n(input logic wide, input logic a0);
    return !(wide || a0);
  endfunction

  // Lane carrying the current cycle's data.
  function automatic lane_e f_lane(input logic wide, input logic card16, input logic a0);
    if (wide) return LANE_BOTH;
    if (card16 && a0) return LANE_HI;
    return LANE_LO;
  endfunction

endpackage

// File: rtl/isa_seq_fsm.sv
module isa_seq_fsm
  import isa_seq_pkg::*;
#(
  parameter int DATA_CYC = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    split,
  output seq_st_e st,
  output logic    in_data,
  output logic    phase_last,
  output logic    second,
  output logic    bus_active
);
  localparam int CW = (DATA_CYC > 1) ? $clog2(DATA_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DATA_CYC - 1);

  seq_st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_ADDR;
      ST_ADDR:  begin st_d = ST_DATA1; cnt_d = '0; end
      ST_DATA1: begin
        if (cnt_q == CNT_LAST) st_d = split ? ST_INCR : ST_DONE;
        else cnt_d = cnt_q + CW'(1);
      end
      ST_INCR:  begin st_d = ST_DATA2; cnt_d = '0; end
      ST_DATA2: begin
        if (cnt_q == CNT_LAST) st_d = ST_DONE;
        else cnt_d = cnt_q + CW'(1);
      end
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st         = st_q;
  assign in_data    = (st_q == ST_DATA1) || (st_q == ST_DATA2);
  assign phase_last = in_data && (cnt_q == CNT_LAST);
  assign second     = (st_q == ST_INCR) || (st_q == ST_DATA2);
  assign bus_active = (st_q == ST_ADDR) || in_data || (st_q == ST_INCR);

  // R10: the data-phase counter never passes the phase length
  p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> (cnt_q <= CNT_LAST));

  // R10: every data phase is entered from the address phase or the step
  p_data_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_data) |-> ($past(st_q) == ST_ADDR || $past(st_q) == ST_INCR));

endmodule

// File: rtl/isa_lane_steer.sv
module isa_lane_steer
  import isa_seq_pkg::*;
(
  input  lane_e       lane,
  input  logic        drive_en,
  input  logic [15:0] wbits,
  input  logic [15:0] din,
  output logic [15:0] dout,
  output logic        oe_lo,
  output logic        oe_hi,
  output logic [7:0]  rd_byte
);
  localparam int NL = 2;

  logic [NL-1:0] sel;
  logic [NL-1:0] oe;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    localparam lane_e MY = (g == 0) ? LANE_LO : LANE_HI;
    assign sel[g] = (lane == LANE_BOTH) || (lane == MY);
    assign dout[8*g +: 8] = !sel[g] ? 8'h00 :
                            (lane == LANE_BOTH) ? wbits[8*g +: 8] : wbits[7:0];
    assign oe[g] = drive_en && sel[g];
  end

  assign oe_lo   = oe[0];
  assign oe_hi   = oe[1];
  assign rd_byte = (lane == LANE_HI) ? din[15:8] : din[7:0];

endmodule

// File: rtl/isa_rd_merge.sv
module isa_rd_merge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap,
  input  logic        second,
  input  logic        wide,
  input  logic [7:0]  rd_byte,
  input  logic [15:0] din,
  output logic [15:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap) begin
      if (wide)        rdata        <= din;
      else if (second) rdata[15:8]  <= rd_byte;
      else             rdata        <= {8'h00, rd_byte};
    end
  end

  // R11: a second-cycle capture leaves the first byte untouched
  p_keep_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && second) |=> $stable(rdata[7:0]));

endmodule

// File: rtl/isa_size_seq.sv
module isa_size_seq
  import isa_seq_pkg::*;
#(
  parameter int AW       = 24,
  parameter int DATA_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          req_stall,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_sbhe_n,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  input  logic          bus_cs16_n,
  output logic [15:0]   bus_dout,
  output logic          bus_oe_lo,
  output logic          bus_oe_hi,
  input  logic [15:0]   bus_din
);
  seq_st_e st;
  logic in_data, phase_last, second, bus_active;

  logic          write_q, word_q, cs16_q, split_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   wdata_q;

  // named internal events
  logic  accept, step_addr, cap, wide, drive_en;
  lane_e lane;
  logic [15:0] wbits;
  logic [7:0]  rd_byte;

  assign accept    = req_valid && (st == ST_IDLE);
  assign step_addr = (st == ST_DATA1) && phase_last && split_q;

  isa_seq_fsm #(.DATA_CYC(DATA_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .split      (split_q),
    .st         (st),
    .in_data    (in_data),
    .phase_last (phase_last),
    .second     (second),
    .bus_active (bus_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cs16_q  <= 1'b0;
      split_q <= 1'b0;
    end else begin
      if (accept) begin
        write_q <= req_write;
        word_q  <= req_word;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (st == ST_ADDR) begin
        cs16_q  <= !bus_cs16_n;
        split_q <= f_split(word_q, !bus_cs16_n, addr_q[0]);
      end
      if (step_addr) addr_q <= addr_q + AW'(1);
    end
  end

  assign wide     = word_q && !split_q && !second;
  assign lane     = f_lane(wide, cs16_q, addr_q[0]);
  assign wbits    = second ? {8'h00, wdata_q[15:8]} : wdata_q;
  assign drive_en = in_data && write_q;
  assign cap      = phase_last && !write_q;

  isa_lane_steer u_steer (
    .lane     (lane),
    .drive_en (drive_en),
    .wbits    (wbits),
    .din      (bus_din),
    .dout     (bus_dout),
    .oe_lo    (bus_oe_lo),
    .oe_hi    (bus_oe_hi),
    .rd_byte  (rd_byte)
  );

  isa_rd_merge u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (cap),
    .second  (second),
    .wide    (wide),
    .rd_byte (rd_byte),
    .din     (bus_din),
    .rdata   (rsp_rdata)
  );

  assign bus_addr   = addr_q;
  assign bus_sbhe_n = bus_active ? f_sbhe_n(word_q && !second, addr_q[0]) : 1'b1;
  assign bus_rd_n   = !(in_data && !write_q);
  assign bus_wr_n   = !(in_data && write_q);
  assign req_stall  = (st != ST_IDLE);
  assign rsp_valid  = (st == ST_DONE);

  // R2: byte-high disabled together with an odd address never appears on the bus
  p_sbhe_a0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_active |-> !(bus_sbhe_n && bus_addr[0]));

  // R3: the width sample holds after the address phase
  p_cs16_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INCR || st == ST_DATA2 || st == ST_DONE) |-> $stable(cs16_q));

  // R6: the second cycle sits one byte above the first
  p_incr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INCR) |-> (bus_addr == $past(bus_addr) + AW'(1)));

  // R8: the second cycle of a split uses only the lower lane
  p_second_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (second && bus_oe_hi) |-> 1'b0);

  // R9: acceptance raises the stall on the next clock
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_stall) |=> (req_stall && !rsp_valid));

  // R9: the response appears while the host is still held
  p_stall_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_stall);

  // R10: read and write strobes are never low together
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  // R11: the response lasts one clock
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R12: lanes are enabled only under the write strobe
  p_oe_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe_lo || bus_oe_hi) |-> !bus_wr_n);

endmodule

// File: tb/isa_size_seq_tb.sv
`timescale 1ns/1ps
module isa_size_seq_tb;
  localparam int AW = 24;
  localparam int DC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid, req_write, req_word;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_wdata;
  logic          req_stall, rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic          bus_sbhe_n, bus_rd_n, bus_wr_n, bus_cs16_n;
  logic [15:0]   bus_dout, bus_din;
  logic          bus_oe_lo, bus_oe_hi;

  isa_size_seq #(.AW(AW), .DATA_CYC(DC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_stall(req_stall), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_sbhe_n(bus_sbhe_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_cs16_n(bus_cs16_n), .bus_dout(bus_dout),
    .bus_oe_lo(bus_oe_lo), .bus_oe_hi(bus_oe_hi), .bus_din(bus_din)
  );

  // ---------------- card model: address bit 8 set = 16-bit card ----------------
  logic [7:0] card_mem [512];
  logic [7:0] shadow   [512];
  logic       cs_glitch = 1'b0;
  logic       card16;
  logic [8:0] ci;
  logic [7:0] lane_lo_v, lane_hi_v;

  assign card16     = bus_addr[8];
  assign ci         = bus_addr[8:0];
  assign bus_cs16_n = (cs_glitch && !(bus_rd_n && bus_wr_n)) ? card16 : !card16;
  assign bus_din    = card16 ? {card_mem[{ci[8:1], 1'b1}], card_mem[{ci[8:1], 1'b0}]}
                             : {8'hEE, card_mem[ci]};

  always @(negedge clk) begin
    if (rst_n && !bus_wr_n) begin
      lane_lo_v = bus_oe_lo ? bus_dout[7:0]  : 8'h5A;
      lane_hi_v = bus_oe_hi ? bus_dout[15:8] : 8'h5A;
      if (card16) begin
        if (!bus_addr[0]) card_mem[{ci[8:1], 1'b0}] = lane_lo_v;
        if (!bus_sbhe_n)  card_mem[{ci[8:1], 1'b1}] = lane_hi_v;
      end else begin
        card_mem[ci] = lane_lo_v;
      end
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  typedef struct {
    logic [AW-1:0] a;
    logic          sbhe_n;
    logic          wr;
    logic          oe_lo;
    logic          oe_hi;
    logic [15:0]   d;
    string         rq;
  } bus_item_t;

  typedef struct {
    logic        wr;
    logic [15:0] d;
    string       rq;
  } rsp_item_t;

  bus_item_t exp_bus[$];
  rsp_item_t exp_rsp[$];

  // ---------------- monitor ----------------
  logic strobe, prev_strobe = 1'b0;
  int   run_len = 0;
  bit   sb_bad = 0, oe_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      strobe = !bus_rd_n || !bus_wr_n;
      if (strobe && bus_sbhe_n && bus_addr[0]) sb_bad = 1;
      if (!strobe && (bus_oe_lo || bus_oe_hi)) oe_bad = 1;
      if (strobe && !prev_strobe) begin
        run_len = 1;
        if (exp_bus.size() == 0) begin
          chk(1'b0, "R9", "unexpected bus cycle at addr", 32'(bus_addr), 0);
        end else begin
          bus_item_t it;
          it = exp_bus.pop_front();
          chk(bus_addr == it.a, it.rq, "cycle address", 32'(bus_addr), 32'(it.a));
          chk(bus_sbhe_n == it.sbhe_n, "R2", "byte-high enable", bus_sbhe_n, it.sbhe_n);
          chk(!bus_wr_n == it.wr, "R10", "strobe kind (1=write)", !bus_wr_n, it.wr);
          chk({bus_oe_hi, bus_oe_lo} == {it.oe_hi, it.oe_lo}, it.rq,
              "lane enables {hi,lo}", {bus_oe_hi, bus_oe_lo}, {it.oe_hi, it.oe_lo});
          if (it.oe_lo) chk(bus_dout[7:0] == it.d[7:0], it.rq, "lower lane data",
                            bus_dout[7:0], it.d[7:0]);
          if (it.oe_hi) chk(bus_dout[15:8] == it.d[15:8], it.rq, "upper lane data",
                            bus_dout[15:8], it.d[15:8]);
        end
      end else if (strobe) begin
        run_len++;
      end
      if (!strobe && prev_strobe)
        chk(run_len == DC, "R10", "strobe length", run_len, DC);
      if (rsp_valid) begin
        if (exp_rsp.size() == 0) begin
          chk(1'b0, "R11", "unexpected response", 0, 0);
        end else begin
          rsp_item_t r;
          r = exp_rsp.pop_front();
          if (!r.wr) chk(rsp_rdata == r.d, r.rq, "read result", rsp_rdata, r.d);
        end
      end
      prev_strobe = strobe;
    end
  end

  // ---------------- driver ----------------
  task automatic do_req(input bit wr, input bit word, input logic [AW-1:0] a,
                        input logic [15:0] wd, input string rq, input bit hold);
    bit            is16, odd, split;
    logic [AW-1:0] a2;
    bus_item_t     it, it2;
    rsp_item_t     r;
    int            n, exp_n;
    is16  = a[8];
    odd   = a[0];
    split = word && (!is16 || odd);
    a2    = a + AW'(1);

    it.a = a; it.sbhe_n = !(word || odd); it.wr = wr; it.rq = rq;
    if (word && !split) begin
      it.oe_lo = 1; it.oe_hi = 1; it.d = wd;
    end else if (is16 && odd) begin
      it.oe_lo = 0; it.oe_hi = 1; it.d = {wd[7:0], 8'h00};
    end else begin
      it.oe_lo = 1; it.oe_hi = 0; it.d = {8'h00, wd[7:0]};
    end
    if (!wr) begin it.oe_lo = 0; it.oe_hi = 0; end
    exp_bus.push_back(it);
    if (split) begin
      it2.a = a2; it2.sbhe_n = !a2[0]; it2.wr = wr; it2.rq = rq;
      it2.oe_lo = wr; it2.oe_hi = 0; it2.d = {8'h00, wd[15:8]};
      exp_bus.push_back(it2);
    end

    r.wr = wr; r.rq = rq;
    r.d  = word ? {shadow[a2[8:0]], shadow[a[8:0]]} : {8'h00, shadow[a[8:0]]};
    exp_rsp.push_back(r);
    if (wr) begin
      shadow[a[8:0]] = wd[7:0];
      if (word) shadow[a2[8:0]] = wd[15:8];
    end

    @(negedge clk);
    req_valid = 1; req_write = wr; req_word = word; req_addr = a; req_wdata = wd;
    @(negedge clk);
    if (hold) begin
      req_addr = a ^ AW'(5); req_write = !wr; req_word = !word; req_wdata = ~wd;
    end else begin
      req_valid = 0;
    end
    n = 1;
    chk(req_stall == 1, "R9", "stall after accept", req_stall, 1);
    while (!rsp_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    req_valid = 0;
    exp_n = split ? (2 * DC + 3) : (DC + 2);
    chk(n == exp_n, "R9", "clocks from accept to response", n, exp_n);
    chk(oe_bad == 0, "R12", "lane enable outside write strobe", oe_bad, 0);
    chk(sb_bad == 0, "R2", "byte-high off with odd address", sb_bad, 0);
    oe_bad = 0; sb_bad = 0;
    @(negedge clk);
    chk(req_stall == 0, "R9", "stall released after response", req_stall, 0);
    chk(exp_bus.size() == 0, rq, "bus cycles still outstanding", exp_bus.size(), 0);
    chk(exp_rsp.size() == 0, "R11", "responses outstanding", exp_rsp.size(), 0);
  endtask

  task automatic chk_idle(input string what);
    chk({req_stall, rsp_valid, bus_rd_n, bus_wr_n, bus_oe_lo, bus_oe_hi, bus_sbhe_n}
        == 7'b0011001, "R1", what,
        {req_stall, rsp_valid, bus_rd_n, bus_wr_n, bus_oe_lo, bus_oe_hi, bus_sbhe_n},
        7'b0011001);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    for (int i = 0; i < 512; i++) begin
      card_mem[i] = 8'(i * 7 + 3);
      shadow[i]   = 8'(i * 7 + 3);
    end
    req_valid = 0; req_write = 0; req_word = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk_idle("outputs during reset");
    rst_n = 1;
    @(negedge clk);
    chk_idle("outputs after reset");

    // R4: byte reads, 8-bit card, even then odd
    do_req(0, 0, 24'h000010, 16'h0, "R4", 0);
    do_req(0, 0, 24'h000011, 16'h0, "R4", 0);
    // R5: byte reads, 16-bit card, even then odd
    do_req(0, 0, 24'h000120, 16'h0, "R5", 0);
    do_req(0, 0, 24'h000121, 16'h0, "R5", 0);
    // R4: byte write to an odd address of an 8-bit card, read back
    do_req(1, 0, 24'h000013, 16'h00A5, "R4", 0);
    do_req(0, 0, 24'h000013, 16'h0, "R4", 0);
    // R5: byte write to an odd address of a 16-bit card, read back as byte and word
    do_req(1, 0, 24'h000125, 16'h003C, "R5", 0);
    do_req(0, 0, 24'h000125, 16'h0, "R5", 0);
    do_req(0, 1, 24'h000124, 16'h0, "R7", 0);
    // R6: words to an 8-bit card, even and odd
    do_req(1, 1, 24'h000020, 16'hBEEF, "R6", 0);
    do_req(0, 1, 24'h000020, 16'h0, "R6", 0);
    do_req(1, 1, 24'h000031, 16'h1234, "R6", 0);
    do_req(0, 1, 24'h000031, 16'h0, "R6", 0);
    // R7: word to a 16-bit card at an even address
    do_req(1, 1, 24'h000140, 16'hCAFE, "R7", 0);
    do_req(0, 1, 24'h000140, 16'h0, "R7", 0);
    // R8: word to a 16-bit card at an odd address, then reads across the pair
    do_req(1, 1, 24'h000151, 16'h5678, "R8", 0);
    do_req(0, 1, 24'h000151, 16'h0, "R8", 0);
    do_req(0, 1, 24'h000150, 16'h0, "R8", 0);
    do_req(0, 1, 24'h000152, 16'h0, "R8", 0);
    do_req(0, 1, 24'h0001FD, 16'h0, "R8", 0);
    // R11: byte read after word traffic returns a zero upper byte
    do_req(0, 0, 24'h000021, 16'h0, "R11", 0);
    // R9: request held valid with changing content while stalled
    do_req(1, 1, 24'h000160, 16'h9ABC, "R9", 1);
    do_req(0, 1, 24'h000160, 16'h0, "R9", 1);
    // R3: width acknowledge flips during data phases; sample from address phase rules
    cs_glitch = 1;
    do_req(0, 1, 24'h000140, 16'h0, "R3", 0);
    do_req(1, 0, 24'h000041, 16'h0077, "R3", 0);
    cs_glitch = 0;
    do_req(0, 0, 24'h000041, 16'h0, "R3", 0);

    chk_idle("idle after traffic");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule